// File: doc/BRIEF.md
# I2C Pin Takeover Port

This block sits between an I2C controller's protocol engine and its two open-drain pads. While the port is in engine mode, the engine's pull-down requests pass straight through to the pads. When software sets the takeover bit, the pads are driven from per-pin output latches instead. Software can then clock the bus by hand to free a target that is holding SDA low.

Software reaches the port through a 16-bit register interface. It has a mode register and a direction register. It has a level register that returns the synchronized pad levels. It has a set register and a clear register, and each moves only the latch bits written as 1. Both pads are open drain: a latch value of 0 turns the pull-down on, and a value of 1 releases the line. The synchronized pad levels also go back to the engine.

Top module: `i2c_pin_takeover`

## Requirements
- R1: After reset the mode register and the direction register read 0, both output latches read 1 at the set address, and neither pad is pulled.
- R2: With mode bit 0 clear, `scl_pull` and `sda_pull` equal `eng_scl_pull` and `eng_sda_pull` as sampled one clock earlier.
- R3: With mode bit 0 set (offset 0), the engine's pull requests have no effect on the pads.
- R4: In takeover mode, direction bit 0 (offset 1) makes SCL an output and bit 1 makes SDA an output. A pad whose direction bit is 0 is released whatever its latch holds. An output pad is pulled exactly when its latch is 0, one clock after the latch or direction changes.
- R5: Writing offset 3 sets latch bit 0 (SCL) or bit 1 (SDA) for every data bit 0 or 1 written as 1. Bits written as 0, and data bits above bit 1, leave the latches unchanged.
- R6: Writing offset 4 clears latch bit 0 (SCL) or bit 1 (SDA) for every data bit written as 1. Zeros have no effect.
- R7: Reading offset 2 returns the SCL pad level in bit 0 and the SDA level in bit 1. The path goes through a two-flop synchronizer and the registered read port, so a pad change appears on `bus_rdata` on the third rising edge after it. Writes to offset 2 are ignored.
- R8: Reading offset 3 returns the output latches (bit 0 SCL, bit 1 SDA). Reading offset 4 or any unused offset returns 0, and `bus_rdata` is registered.
- R9: Switching the mode in either direction keeps the direction register and the latches unchanged.
- R10: `eng_scl_lvl` and `eng_sda_lvl` carry the synchronized pad levels two rising edges after a pad change, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for `bus_addr` |
| eng_scl_pull | input | 1 | Engine request to pull SCL low |
| eng_sda_pull | input | 1 | Engine request to pull SDA low |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| scl_pull | output | 1 | Open-drain pull-down enable for SCL |
| sda_pull | output | 1 | Open-drain pull-down enable for SDA |
| eng_scl_lvl | output | 1 | Synchronized SCL level for the engine |
| eng_sda_lvl | output | 1 | Synchronized SDA level for the engine |

## Verification
A corrupted output latch shows at the set-address readback on the next read cycle. If its pad is an output in takeover mode, the wrong latch value also shows as a wrong pull one clock after the write. A stuck mode or direction bit shows at the pads one clock after the engine request or the latch moves, because the pulls follow a different source. A wrong synchronizer depth moves the level readback off its third edge and the engine level off its second, so the exact-latency checks detect it.

// File: rtl/i2c_pin_takeover_pkg.sv
package i2c_pin_takeover_pkg;
  localparam int NUM_PINS = 2;
  localparam int PIN_SCL  = 0;
  localparam int PIN_SDA  = 1;

  // Register offsets; bit positions inside each register follow the pin index.
  typedef enum logic [2:0] {
    OFS_MODE  = 3'd0,
    OFS_DIR   = 3'd1,
    OFS_LEVEL = 3'd2,
    OFS_SET   = 3'd3,
    OFS_CLR   = 3'd4
  } reg_ofs_e;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_pin_regs.sv
module i2c_pin_regs
  import i2c_pin_takeover_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] level,
  output logic [DATA_W-1:0]   rdata,
  output logic                mode_q,
  output logic [NUM_PINS-1:0] dir_q,
  output logic [NUM_PINS-1:0] out_q
);
  localparam int PAD_W = DATA_W - NUM_PINS;

  logic hit_mode, hit_dir, hit_set, hit_clr;
  logic [DATA_W-1:0] rd_next;

  assign hit_mode = wr && (addr == ADDR_W'(OFS_MODE));
  assign hit_dir  = wr && (addr == ADDR_W'(OFS_DIR));
  assign hit_set  = wr && (addr == ADDR_W'(OFS_SET));
  assign hit_clr  = wr && (addr == ADDR_W'(OFS_CLR));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      dir_q  <= '0;
    end else begin
      if (hit_mode) mode_q <= wdata[0];
      if (hit_dir)  dir_q  <= wdata[NUM_PINS-1:0];
    end
  end

  // Per-pin write-one set/clear latches, reset released (high).
  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_latch
      always_ff @(posedge clk) begin
        if (rst) out_q[p] <= 1'b1;
        else if (hit_set && wdata[p]) out_q[p] <= 1'b1;
        else if (hit_clr && wdata[p]) out_q[p] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(OFS_MODE):  rd_next = {{(DATA_W-1){1'b0}}, mode_q};
      ADDR_W'(OFS_DIR):   rd_next = {{PAD_W{1'b0}}, dir_q};
      ADDR_W'(OFS_LEVEL): rd_next = {{PAD_W{1'b0}}, level};
      ADDR_W'(OFS_SET):   rd_next = {{PAD_W{1'b0}}, out_q};
      default:            rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else rdata <= rd_next;
  end
endmodule

// File: rtl/i2c_pin_drive.sv
module i2c_pin_drive (
  input  logic clk,
  input  logic rst,
  input  logic takeover,
  input  logic is_output,
  input  logic latch,
  input  logic eng_pull,
  output logic pull
);
  logic pull_next;

  always_comb begin
    if (takeover) pull_next = is_output && !latch;
    else pull_next = eng_pull;
  end

  always_ff @(posedge clk) begin
    if (rst) pull <= 1'b0;
    else pull <= pull_next;
  end
endmodule

// File: rtl/i2c_pin_takeover.sv
module i2c_pin_takeover
  import i2c_pin_takeover_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_scl_pull,
  input  logic              eng_sda_pull,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_pull,
  output logic              sda_pull,
  output logic              eng_scl_lvl,
  output logic              eng_sda_lvl
);
  logic                mode_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] sync_q;
  logic [NUM_PINS-1:0] pad_raw;
  logic [NUM_PINS-1:0] eng_req;
  logic [NUM_PINS-1:0] pull_vec;

  assign pad_raw[PIN_SCL] = scl_in;
  assign pad_raw[PIN_SDA] = sda_in;
  assign eng_req[PIN_SCL] = eng_scl_pull;
  assign eng_req[PIN_SDA] = eng_sda_pull;

  i2c_pin_sync #(
    .WIDTH(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL('1)
  ) u_sync (
    .clk(clk), .rst(rst), .d(pad_raw), .q(sync_q)
  );

  i2c_pin_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .level(sync_q), .rdata(bus_rdata),
    .mode_q(mode_q), .dir_q(dir_q), .out_q(out_q)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pad
      i2c_pin_drive u_drv (
        .clk(clk), .rst(rst), .takeover(mode_q), .is_output(dir_q[p]),
        .latch(out_q[p]), .eng_pull(eng_req[p]), .pull(pull_vec[p])
      );
    end
  endgenerate

  assign scl_pull    = pull_vec[PIN_SCL];
  assign sda_pull    = pull_vec[PIN_SDA];
  assign eng_scl_lvl = sync_q[PIN_SCL];
  assign eng_sda_lvl = sync_q[PIN_SDA];
endmodule

// File: rtl/i2c_pin_takeover_chk.sv
module i2c_pin_takeover_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [1:0]        wbits,
  input logic              eng_scl_pull,
  input logic              eng_sda_pull,
  input logic              scl_in,
  input logic              sda_in,
  input logic              scl_pull,
  input logic              sda_pull,
  input logic              mode_q,
  input logic [1:0]        dir_q,
  input logic [1:0]        out_q,
  input logic [1:0]        sync_q
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (out_q == 2'b11) && !mode_q && (dir_q == 2'b00) && !scl_pull && !sda_pull);

  assert_engine_scl_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_q)) |-> scl_pull == $past(eng_scl_pull));

  assert_engine_sda_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(mode_q)) |-> sda_pull == $past(eng_sda_pull));

  assert_input_released_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_q) && !$past(dir_q[1])) |-> !sda_pull);

  assert_latch_drives_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_q) && $past(dir_q[0])) |-> scl_pull == !$past(out_q[0]));

  assert_set_one_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(3) && wbits[1]) |=> out_q[1]);

  assert_set_zero_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(3) && !wbits[0]) |=> out_q[0] == $past(out_q[0]));

  assert_clear_one_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(4) && wbits[0]) |=> !out_q[0]);

  assert_sync_depth_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> sync_q == $past({sda_in, scl_in}, 2));
endmodule

bind i2c_pin_takeover i2c_pin_takeover_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .wbits(bus_wdata[1:0]),
  .eng_scl_pull(eng_scl_pull), .eng_sda_pull(eng_sda_pull),
  .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
  .mode_q(mode_q), .dir_q(dir_q), .out_q(out_q), .sync_q(sync_q)
);

// File: tb/test_i2c_pin_takeover.sv
module test_i2c_pin_takeover;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        eng_scl_pull = 1'b0, eng_sda_pull = 1'b0;
  logic        scl_in = 1'b1, sda_in = 1'b1;
  logic        scl_pull, sda_pull, eng_scl_lvl, eng_sda_lvl;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  i2c_pin_takeover i_i2c_pin_takeover (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_scl_pull(eng_scl_pull), .eng_sda_pull(eng_sda_pull),
    .scl_in(scl_in), .sda_in(sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .eng_scl_lvl(eng_scl_lvl), .eng_sda_lvl(eng_sda_lvl)
  );

  // Vector: write op, engine {sda,scl}, pads {sda,scl}, read offset, expected read, expected pulls {sda,scl}
  typedef struct packed {
    logic        wr;
    logic [2:0]  waddr;
    logic [15:0] wdata;
    logic [1:0]  eng;
    logic [1:0]  pad;
    logic [2:0]  raddr;
    logic [15:0] exp_rd;
    logic [1:0]  exp_pull;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd0, 16'h0000, 2'b01, 2'b11, 3'd3, 16'h0003, 2'b01}, // R2 engine SCL pull
    '{1'b0, 3'd0, 16'h0000, 2'b10, 2'b10, 3'd2, 16'h0002, 2'b10}, // R2 R7 SCL low on pad
    '{1'b1, 3'd0, 16'h0001, 2'b11, 2'b11, 3'd0, 16'h0001, 2'b00}, // R3 R4 takeover, inputs
    '{1'b1, 3'd1, 16'h0001, 2'b11, 2'b11, 3'd1, 16'h0001, 2'b00}, // R4 SCL output, latch high
    '{1'b1, 3'd4, 16'h0003, 2'b11, 2'b11, 3'd3, 16'h0000, 2'b01}, // R6 R4 R8 clear both
    '{1'b1, 3'd1, 16'h0003, 2'b00, 2'b11, 3'd1, 16'h0003, 2'b11}, // R4 R3 both outputs
    '{1'b1, 3'd3, 16'h0002, 2'b00, 2'b11, 3'd3, 16'h0002, 2'b01}, // R5 set SDA
    '{1'b1, 3'd3, 16'h0000, 2'b11, 2'b11, 3'd3, 16'h0002, 2'b01}, // R5 zero write
    '{1'b1, 3'd3, 16'hFFFC, 2'b11, 2'b11, 3'd3, 16'h0002, 2'b01}, // R5 upper bits ignored
    '{1'b1, 3'd4, 16'h0000, 2'b11, 2'b11, 3'd3, 16'h0002, 2'b01}, // R6 zero clear
    '{1'b1, 3'd3, 16'h0001, 2'b11, 2'b11, 3'd3, 16'h0003, 2'b00}, // R5 set SCL
    '{1'b1, 3'd4, 16'h0002, 2'b11, 2'b11, 3'd3, 16'h0001, 2'b10}, // R6 clear SDA
    '{1'b1, 3'd2, 16'h0003, 2'b11, 2'b01, 3'd2, 16'h0001, 2'b10}, // R7 write ignored, SDA low
    '{1'b1, 3'd0, 16'h0000, 2'b01, 2'b11, 3'd3, 16'h0001, 2'b01}, // R9 back to engine
    '{1'b1, 3'd0, 16'h0001, 2'b11, 2'b11, 3'd1, 16'h0003, 2'b10}, // R9 R3 takeover again
    '{1'b1, 3'd5, 16'hFFFF, 2'b11, 2'b11, 3'd4, 16'h0000, 2'b10}  // R8 clear/unused read 0
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    bus_addr = 3'd3;
    repeat (2) @(negedge clk);
    check("R1 latches", bus_rdata, 16'h0003);
    check("R1 pulls", {14'h0, sda_pull, scl_pull}, 16'h0000);
    bus_addr = 3'd0; repeat (2) @(negedge clk);
    check("R1 mode", bus_rdata, 16'h0000);
    bus_addr = 3'd1; repeat (2) @(negedge clk);
    check("R1 dir", bus_rdata, 16'h0000);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_wr = VECS[i].wr; bus_addr = VECS[i].waddr; bus_wdata = VECS[i].wdata;
      {eng_sda_pull, eng_scl_pull} = VECS[i].eng;
      {sda_in, scl_in} = VECS[i].pad;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; bus_addr = VECS[i].raddr;
      repeat (4) @(negedge clk);
      check($sformatf("vector %0d read", i), bus_rdata, VECS[i].exp_rd);
      check($sformatf("vector %0d pulls", i), {14'h0, sda_pull, scl_pull}, {14'h0, VECS[i].exp_pull});
    end

    // R2 one-clock latency in engine mode
    wr_reg(3'd0, 16'h0000);
    eng_scl_pull = 1'b0; eng_sda_pull = 1'b0;
    repeat (2) @(negedge clk);
    eng_sda_pull = 1'b1;
    @(negedge clk);
    check("R2 sda pull after one edge", {15'h0, sda_pull}, 16'h0001);

    // R7 / R10 exact synchronizer latency
    scl_in = 1'b1; sda_in = 1'b1; bus_addr = 3'd2;
    repeat (4) @(negedge clk);
    scl_in = 1'b0;
    @(negedge clk);
    check("R10 level not yet after one edge", {15'h0, eng_scl_lvl}, 16'h0001);
    @(negedge clk);
    check("R10 level after two edges", {15'h0, eng_scl_lvl}, 16'h0000);
    check("R7 read not yet after two edges", bus_rdata, 16'h0003);
    @(negedge clk);
    check("R7 read after three edges", bus_rdata, 16'h0002);

    // R6 / R4 latch-to-pad latency in takeover mode
    eng_sda_pull = 1'b0;
    wr_reg(3'd1, 16'h0003);
    wr_reg(3'd3, 16'h0003);
    wr_reg(3'd0, 16'h0001);
    repeat (2) @(negedge clk);
    check("R4 released before clear", {14'h0, sda_pull, scl_pull}, 16'h0000);
    @(negedge clk);
    bus_addr = 3'd4; bus_wr = 1'b1; bus_wdata = 16'h0001;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R6 pull one edge after latch", {15'h0, scl_pull}, 16'h0000);
    @(negedge clk);
    check("R6 pull two edges after write", {15'h0, scl_pull}, 16'h0001);
    // R3 engine request ignored while taken over
    eng_scl_pull = 1'b1; eng_sda_pull = 1'b1;
    repeat (2) @(negedge clk);
    check("R3 engine ignored on SDA", {15'h0, sda_pull}, 16'h0000);
    // R4 direction clear releases SCL despite low latch
    wr_reg(3'd1, 16'h0000);
    @(negedge clk);
    check("R4 input pad released", {15'h0, scl_pull}, 16'h0000);

    summary();
    $finish;
  end
endmodule